// File: doc/BRIEF.md
# Register Spill/Fill Transfer Queue

This block sits between the register rename stage and the single data cache port of an out-of-order core whose physical register file acts as a cache of register values backed by memory. When rename evicts a register it asks for a spill (register to memory). When it needs a register that is not resident it asks for a fill (memory to register). Each request arrives with a fully formed memory address and a physical register number. The queue holds the requests in arrival order and drives them onto the cache port one at a time.

Ordinary load and store instructions share the same port. They are admitted only while the queue is empty and the port is idle. Queue transfers bypass every disambiguation and dependence check, because their addresses were settled at rename. A spill reads its register through a read port in the cycle it is presented to the cache, and retires when the cache acknowledges the write. A fill writes the returned data into its register one cycle after the cache acknowledges it. In that same cycle the block pulses a ready flag that carries the register number, so dependent operands can wake up.

Top module: `spill_fill_queue`

## Requirements
- R1: While reset is held and after it is released with no stimulus, `enq_stall`, `dc_req`, `ins_grant`, `rf_wr_en` and `fill_done` are all 0.
- R2: A request is taken when `enq_valid` is 1 and `enq_stall` is 0. `enq_stall` is 1 exactly while DEPTH requests are held. A request offered while `enq_stall` is 1 is dropped and never reaches the cache port.
- R3: While the queue holds any request, `ins_grant` stays 0 and the cache port carries the head request. An instruction access goes out only when the queue is empty and the port is idle.
- R4: Requests reach the cache port in exactly the order they were taken, whatever mix of spills and fills they are.
- R5: `dc_addr` of a queue transfer equals the address given at enqueue, unchanged.
- R6: A spill (`enq_op` = 0) is presented with `dc_we` = 1, `rf_rd_en` = 1 and `rf_rd_preg` equal to its register, and `dc_wdata` equal to `rf_rd_data` in that cycle.
- R7: A transfer retires in the cycle `dc_ack` is 1. With `dc_ready` held at 1, the next queued request is presented in the cycle after that acknowledge.
- R8: A fill (`enq_op` = 1) is presented with `dc_we` = 0. In the cycle after its `dc_ack`, `rf_wr_en` is 1, `rf_wr_preg` is its register and `rf_wr_data` is the `dc_rdata` seen with the acknowledge. `fill_done` is 1 for exactly that one cycle, with `fill_done_preg` equal to the register.
- R9: At most one access is outstanding on the cache port. After a request is accepted (`dc_req` and `dc_ready` both 1), `dc_req` stays 0 until `dc_ack` arrives.
- R10: `ins_ack` is 1 only for an acknowledge that belongs to an instruction access. An acknowledge for a queue transfer never shows on `ins_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Rename offers a transfer request |
| enq_op | input | 1 | 0 = spill, 1 = fill |
| enq_addr | input | ADDR_W | Precomputed memory address |
| enq_preg | input | PREG_W | Physical register number |
| enq_stall | output | 1 | Queue full; rename must hold |
| ins_req | input | 1 | Instruction access request |
| ins_we | input | 1 | Instruction access is a store |
| ins_addr | input | ADDR_W | Instruction access address |
| ins_wdata | input | DATA_W | Instruction store data |
| ins_grant | output | 1 | Instruction access accepted by the port |
| ins_ack | output | 1 | Instruction access completed |
| ins_rdata | output | DATA_W | Load data for the instruction access |
| dc_req | output | 1 | Cache port request |
| dc_we | output | 1 | Cache port write |
| dc_addr | output | ADDR_W | Cache port address |
| dc_wdata | output | DATA_W | Cache port write data |
| dc_ready | input | 1 | Cache accepts the request this cycle |
| dc_ack | input | 1 | Cache completes the outstanding access |
| dc_rdata | input | DATA_W | Cache read data, valid with dc_ack |
| rf_rd_en | output | 1 | Register file read for a spill |
| rf_rd_preg | output | PREG_W | Register read index |
| rf_rd_data | input | DATA_W | Register read data, same cycle |
| rf_wr_en | output | 1 | Register file write for a fill |
| rf_wr_preg | output | PREG_W | Register write index |
| rf_wr_data | output | DATA_W | Register write data |
| fill_done | output | 1 | One-cycle operand-ready pulse |
| fill_done_preg | output | PREG_W | Register made ready |

## Verification
The bench builds the block with its defaults: a depth of 8, 32-bit addresses and data, and 7-bit register numbers. With a depth of 8, the queue can be driven to full and held there by stalling `dc_ready` for only a few cycles. That makes the stall, the dropped request and the ordered drain of a full queue reachable. The cache model's latency is changed between scenarios (1, 2 and 5 cycles). This exposes the retire-to-next-issue spacing and the rule of one outstanding access, which a fixed short latency would hide.

// File: rtl/sfq_pkg.sv
// Shared encodings for the spill/fill transfer queue.
package sfq_pkg;

    // Kind of a queued register transfer
    typedef enum logic {
        XFER_SPILL = 1'b0,
        XFER_FILL  = 1'b1
    } xfer_op_e;

    // Which requester owns the outstanding cache access
    typedef enum logic {
        OWN_INSN  = 1'b0,
        OWN_QUEUE = 1'b1
    } port_owner_e;

endpackage

// File: rtl/sfq_fifo.sv
// sfq_fifo: circular buffer of DEPTH packed entries.
// Assumes: a push is refused while full and a pop is ignored while empty.
// The head entry is read combinationally and stays valid until popped.
module sfq_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic [WIDTH-1:0] head_data,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] level;
    logic             do_push;
    logic             do_pop;

    // Qualify requests against the current occupancy
    always_comb begin
        do_push = push_req && !full;
        do_pop  = pop_req && !empty;
    end

    // Occupancy flags
    always_comb begin
        empty = (level == '0);
        full  = (level == CNT_W'(DEPTH));
    end

    assign head_data = slots[rd_ptr];

    // Entry storage; written only on an accepted push
    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/sfq_port_arb.sv
// sfq_port_arb: owns the single data cache port.
// The queue head always wins over an instruction access. Only one access
// is outstanding at a time, and the owner is remembered so that the
// acknowledge is routed back to the right requester.
// Assumes: dc_ack comes no earlier than the cycle after acceptance, and
// only while an access is outstanding.
module sfq_port_arb
    import sfq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PREG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    // queue head
    input  logic              q_valid,
    input  xfer_op_e          head_op,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [PREG_W-1:0] head_preg,
    // instruction side
    input  logic              ins_req,
    input  logic              ins_we,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_wdata,
    output logic              ins_grant,
    output logic              ins_ack,
    // register file read port
    output logic              rf_rd_en,
    output logic [PREG_W-1:0] rf_rd_preg,
    input  logic [DATA_W-1:0] rf_rd_data,
    // cache port
    output logic              dc_req,
    output logic              dc_we,
    output logic [ADDR_W-1:0] dc_addr,
    output logic [DATA_W-1:0] dc_wdata,
    input  logic              dc_ready,
    input  logic              dc_ack,
    // queue retirement
    output logic              q_retire
);
    logic        port_busy;
    port_owner_e owner_q;
    logic        q_issue;
    logic        i_issue;
    logic        head_spill;
    logic        ack_hit;

    // Fixed priority: queue head first, instructions only on an empty queue
    always_comb begin
        q_issue    = q_valid && !port_busy;
        i_issue    = ins_req && !q_valid && !port_busy;
        head_spill = (head_op == XFER_SPILL);
    end

    // Cache port multiplexer; spill data comes straight from the register read
    always_comb begin
        dc_req   = q_issue || i_issue;
        dc_we    = q_issue ? head_spill : ins_we;
        dc_addr  = q_issue ? head_addr  : ins_addr;
        dc_wdata = q_issue ? rf_rd_data : ins_wdata;
    end

    // Register read for a spill happens while it is presented
    always_comb begin
        rf_rd_en   = q_issue && head_spill;
        rf_rd_preg = head_preg;
    end

    // Route grant and acknowledge to their owners
    always_comb begin
        ins_grant = i_issue && dc_ready;
        ack_hit   = dc_ack && port_busy;
        ins_ack   = ack_hit && (owner_q == OWN_INSN);
        q_retire  = ack_hit && (owner_q == OWN_QUEUE);
    end

    // Track the single outstanding access and its owner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_busy <= 1'b0;
            owner_q   <= OWN_INSN;
        end else if (ack_hit) begin
            port_busy <= 1'b0;
        end else if (dc_req && dc_ready) begin
            port_busy <= 1'b1;
            owner_q   <= q_issue ? OWN_QUEUE : OWN_INSN;
        end
    end

endmodule

// File: rtl/sfq_fill_wb.sv
// sfq_fill_wb: registers the write-back of a completed fill.
// One cycle after the acknowledge it drives the register file write and a
// one-cycle ready pulse carrying the register number.
// Assumes: retire_fill is high for one cycle per fill.
module sfq_fill_wb #(
    parameter int DATA_W = 32,
    parameter int PREG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_fill,
    input  logic [PREG_W-1:0] retire_preg,
    input  logic [DATA_W-1:0] retire_data,
    output logic              rf_wr_en,
    output logic [PREG_W-1:0] rf_wr_preg,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              fill_done,
    output logic [PREG_W-1:0] fill_done_preg
);
    // Register file write stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_wr_en   <= 1'b0;
            rf_wr_preg <= '0;
            rf_wr_data <= '0;
        end else begin
            rf_wr_en <= retire_fill;
            if (retire_fill) begin
                rf_wr_preg <= retire_preg;
                rf_wr_data <= retire_data;
            end
        end
    end

    // Operand-ready pulse toward the scheduler
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_done      <= 1'b0;
            fill_done_preg <= '0;
        end else begin
            fill_done <= retire_fill;
            if (retire_fill) begin
                fill_done_preg <= retire_preg;
            end
        end
    end

endmodule

// File: rtl/spill_fill_queue.sv
// spill_fill_queue: ordered queue of register spills and fills sharing the
// data cache port with instruction accesses, with strict priority for the
// queue.
// Assumes: addresses arrive fully formed from rename, and no disambiguation
// against in-flight loads and stores is needed. The register read port
// returns data in the same cycle.
module spill_fill_queue
    import sfq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PREG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic              enq_op,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [PREG_W-1:0] enq_preg,
    output logic              enq_stall,
    input  logic              ins_req,
    input  logic              ins_we,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_wdata,
    output logic              ins_grant,
    output logic              ins_ack,
    output logic [DATA_W-1:0] ins_rdata,
    output logic              dc_req,
    output logic              dc_we,
    output logic [ADDR_W-1:0] dc_addr,
    output logic [DATA_W-1:0] dc_wdata,
    input  logic              dc_ready,
    input  logic              dc_ack,
    input  logic [DATA_W-1:0] dc_rdata,
    output logic              rf_rd_en,
    output logic [PREG_W-1:0] rf_rd_preg,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [PREG_W-1:0] rf_wr_preg,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              fill_done,
    output logic [PREG_W-1:0] fill_done_preg
);
    localparam int ENTRY_W = 1 + ADDR_W + PREG_W;

    logic [ENTRY_W-1:0] head_bits;
    logic               q_empty;
    logic               q_full;
    logic               q_retire;
    xfer_op_e           head_op;
    logic [ADDR_W-1:0]  head_addr;
    logic [PREG_W-1:0]  head_preg;
    logic               retire_fill;

    // Unpack the head entry into its fields
    always_comb begin
        head_op   = xfer_op_e'(head_bits[ENTRY_W-1]);
        head_addr = head_bits[PREG_W +: ADDR_W];
        head_preg = head_bits[PREG_W-1:0];
    end

    // A fill retires toward write-back; a spill simply leaves the queue
    always_comb begin
        retire_fill = q_retire && (head_op == XFER_FILL);
        enq_stall   = q_full;
        ins_rdata   = dc_rdata;
    end

    sfq_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (ENTRY_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (enq_valid),
        .push_data ({enq_op, enq_addr, enq_preg}),
        .pop_req   (q_retire),
        .head_data (head_bits),
        .empty     (q_empty),
        .full      (q_full)
    );

    sfq_port_arb #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PREG_W (PREG_W)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_valid    (!q_empty),
        .head_op    (head_op),
        .head_addr  (head_addr),
        .head_preg  (head_preg),
        .ins_req    (ins_req),
        .ins_we     (ins_we),
        .ins_addr   (ins_addr),
        .ins_wdata  (ins_wdata),
        .ins_grant  (ins_grant),
        .ins_ack    (ins_ack),
        .rf_rd_en   (rf_rd_en),
        .rf_rd_preg (rf_rd_preg),
        .rf_rd_data (rf_rd_data),
        .dc_req     (dc_req),
        .dc_we      (dc_we),
        .dc_addr    (dc_addr),
        .dc_wdata   (dc_wdata),
        .dc_ready   (dc_ready),
        .dc_ack     (dc_ack),
        .q_retire   (q_retire)
    );

    sfq_fill_wb #(
        .DATA_W (DATA_W),
        .PREG_W (PREG_W)
    ) u_wb (
        .clk            (clk),
        .rst_n          (rst_n),
        .retire_fill    (retire_fill),
        .retire_preg    (head_preg),
        .retire_data    (dc_rdata),
        .rf_wr_en       (rf_wr_en),
        .rf_wr_preg     (rf_wr_preg),
        .rf_wr_data     (rf_wr_data),
        .fill_done      (fill_done),
        .fill_done_preg (fill_done_preg)
    );

endmodule

// File: rtl/sfq_checker.sv
// sfq_checker: temporal properties of spill_fill_queue, bound to every
// instance. It keeps its own record of whether a cache access is
// outstanding.
module sfq_checker #(
    parameter int DATA_W = 32,
    parameter int PREG_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              q_empty,
    input logic              enq_stall,
    input logic              ins_grant,
    input logic              ins_ack,
    input logic              dc_req,
    input logic              dc_we,
    input logic [DATA_W-1:0] dc_wdata,
    input logic              dc_ready,
    input logic              dc_ack,
    input logic              rf_rd_en,
    input logic [DATA_W-1:0] rf_rd_data,
    input logic              rf_wr_en,
    input logic [PREG_W-1:0] rf_wr_preg,
    input logic              fill_done,
    input logic [PREG_W-1:0] fill_done_preg
);
    logic pending;

    // Independent view of the port: set on acceptance, cleared on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (dc_ack) begin
            pending <= 1'b0;
        end else if (dc_req && dc_ready) begin
            pending <= 1'b1;
        end
    end

    // R2: a full queue stays full until some acknowledge can free a slot
    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_stall && !dc_ack) |=> enq_stall);

    // R3: an instruction access is granted only on an empty queue
    assert_queue_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ins_grant |-> q_empty);

    // R6: a queued write carries the register read data
    assert_spill_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_req && dc_we && !q_empty) |-> (rf_rd_en && dc_wdata == rf_rd_data));

    // R8: ready pulse is one cycle wide
    assert_fill_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_done);

    // R8: ready pulse coincides with the register write of the same register
    assert_fill_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (rf_wr_en && rf_wr_preg == fill_done_preg));

    // R8: the write-back follows an acknowledge by one cycle
    assert_fill_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> $past(dc_ack));

    // R9: no new request while one is outstanding
    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !dc_req);

    // R10: instruction acknowledge only from a real acknowledge of a pending access
    assert_ins_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ack |-> (dc_ack && pending));

endmodule

bind spill_fill_queue sfq_checker #(
    .DATA_W (DATA_W),
    .PREG_W (PREG_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .q_empty        (q_empty),
    .enq_stall      (enq_stall),
    .ins_grant      (ins_grant),
    .ins_ack        (ins_ack),
    .dc_req         (dc_req),
    .dc_we          (dc_we),
    .dc_wdata       (dc_wdata),
    .dc_ready       (dc_ready),
    .dc_ack         (dc_ack),
    .rf_rd_en       (rf_rd_en),
    .rf_rd_data     (rf_rd_data),
    .rf_wr_en       (rf_wr_en),
    .rf_wr_preg     (rf_wr_preg),
    .fill_done      (fill_done),
    .fill_done_preg (fill_done_preg)
);

// File: tb/sim_spill_fill_queue.sv
`timescale 1ns/1ps
// Directed bench: a behavioural cache with adjustable latency and a
// register file model built from simple functions of the address/index.
module sim_spill_fill_queue;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int PW = 7;
    localparam bit OP_SPILL = 1'b0;
    localparam bit OP_FILL  = 1'b1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enq_valid, enq_op;
    logic [AW-1:0] enq_addr;
    logic [PW-1:0] enq_preg;
    logic          enq_stall;
    logic          ins_req, ins_we;
    logic [AW-1:0] ins_addr;
    logic [DW-1:0] ins_wdata;
    logic          ins_grant, ins_ack;
    logic [DW-1:0] ins_rdata;
    logic          dc_req, dc_we;
    logic [AW-1:0] dc_addr;
    logic [DW-1:0] dc_wdata;
    logic          dc_ready, dc_ack;
    logic [DW-1:0] dc_rdata;
    logic          rf_rd_en;
    logic [PW-1:0] rf_rd_preg;
    logic [DW-1:0] rf_rd_data;
    logic          rf_wr_en;
    logic [PW-1:0] rf_wr_preg;
    logic [DW-1:0] rf_wr_data;
    logic          fill_done;
    logic [PW-1:0] fill_done_preg;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    spill_fill_queue u0 (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_op(enq_op), .enq_addr(enq_addr),
        .enq_preg(enq_preg), .enq_stall(enq_stall),
        .ins_req(ins_req), .ins_we(ins_we), .ins_addr(ins_addr),
        .ins_wdata(ins_wdata), .ins_grant(ins_grant), .ins_ack(ins_ack),
        .ins_rdata(ins_rdata),
        .dc_req(dc_req), .dc_we(dc_we), .dc_addr(dc_addr), .dc_wdata(dc_wdata),
        .dc_ready(dc_ready), .dc_ack(dc_ack), .dc_rdata(dc_rdata),
        .rf_rd_en(rf_rd_en), .rf_rd_preg(rf_rd_preg), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_preg(rf_wr_preg), .rf_wr_data(rf_wr_data),
        .fill_done(fill_done), .fill_done_preg(fill_done_preg)
    );

    // Models: register contents and memory contents as fixed functions
    logic [AW-1:0] cur_addr = '0;
    assign rf_rd_data = 32'h5000_0000 | 32'(rf_rd_preg);
    assign dc_rdata   = cur_addr ^ 32'hF0F0_0000;

    // Cache model: logs accepted requests, acknowledges after lat cycles
    int       lat = 1;
    int       cnt = 0;
    int       cyc = 0;
    int       viol = 0;
    int       lg_n = 0;
    bit       lg_we   [64];
    bit [31:0] lg_addr [64];
    bit [31:0] lg_wdata[64];
    int       lg_cyc  [64];
    bit       busy_now;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            cnt    = 0;
            dc_ack = 1'b0;
        end else begin
            busy_now = (cnt > 0);
            dc_ack   = (cnt == 1);
            if (cnt > 0) cnt--;
            #1;
            if (busy_now && dc_req) viol++;
            if (dc_req && dc_ready) begin
                if (lg_n < 64) begin
                    lg_we[lg_n]    = dc_we;
                    lg_addr[lg_n]  = dc_addr;
                    lg_wdata[lg_n] = dc_wdata;
                    lg_cyc[lg_n]   = cyc;
                end
                lg_n++;
                cnt      = lat;
                cur_addr = dc_addr;
            end
        end
    end

    // Write-back monitor: records ready pulses and their data
    int        fd_n = 0;
    int        fd_cycles = 0;
    int        wb_mis = 0;
    int        n_insack = 0;
    bit        fd_prev = 1'b0;
    bit [PW-1:0] fd_preg[64];
    bit [31:0] fd_data[64];

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (fill_done) begin
                fd_cycles++;
                if (!fd_prev && fd_n < 64) begin
                    fd_preg[fd_n] = fill_done_preg;
                    fd_data[fd_n] = rf_wr_data;
                    if (!rf_wr_en || rf_wr_preg != fill_done_preg) wb_mis++;
                    fd_n++;
                end
            end
            if (rf_wr_en != fill_done) wb_mis++;
            fd_prev = fill_done;
            if (ins_ack) n_insack++;
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Offer one request for one cycle; called at a falling edge
    task automatic push(bit op, logic [AW-1:0] addr, logic [PW-1:0] preg);
        enq_valid = 1'b1;
        enq_op    = op;
        enq_addr  = addr;
        enq_preg  = preg;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic wait_log(int n);
        for (int i = 0; i < 500 && lg_n < n; i++) @(negedge clk);
    endtask

    task automatic wait_fills(int n);
        for (int i = 0; i < 500 && fd_n < n; i++) @(negedge clk);
    endtask

    // R1: quiet outputs in and after reset
    task automatic t_reset();
        #2;
        check("R1 stall in reset", enq_stall, 0);
        check("R1 dc_req in reset", dc_req, 0);
        check("R1 fill_done in reset", fill_done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        check("R1 stall after reset", enq_stall, 0);
        check("R1 dc_req after reset", dc_req, 0);
        check("R1 ins_grant after reset", ins_grant, 0);
        check("R1 rf_wr_en after reset", rf_wr_en, 0);
    endtask

    // R4 R5 R6 R7 R8: spill then two fills, one to the victim register
    task automatic t_order();
        int b = lg_n;
        int f = fd_n;
        int c0 = fd_cycles;
        lat = 2;
        push(OP_SPILL, 32'h0000_0100, 7'd5);
        push(OP_FILL,  32'h0000_0200, 7'd5);
        push(OP_FILL,  32'h0000_0300, 7'd9);
        wait_log(b + 3);
        wait_fills(f + 2);
        repeat (3) @(negedge clk);
        check("R6 spill is write", lg_we[b], 1);
        check("R5 spill address", lg_addr[b], 32'h0000_0100);
        check("R6 spill data from register 5", lg_wdata[b], 32'h5000_0005);
        check("R8 fill is read", lg_we[b+1], 0);
        check("R4 victim fill after spill", lg_addr[b+1], 32'h0000_0200);
        check("R4 third in order", lg_addr[b+2], 32'h0000_0300);
        check("R7 next issue one cycle after ack", lg_cyc[b+1], lg_cyc[b] + lat + 1);
        check("R8 first fill register", fd_preg[f], 5);
        check("R8 first fill data", fd_data[f], 32'hF0F0_0200);
        check("R8 second fill register", fd_preg[f+1], 9);
        check("R8 second fill data", fd_data[f+1], 32'hF0F0_0300);
        check("R8 pulse width total", fd_cycles - c0, 2);
        check("R8 write/pulse agreement", wb_mis, 0);
    endtask

    // R3 R6 R10: queue head beats a waiting instruction
    task automatic t_priority();
        int b = lg_n;
        int ia = n_insack;
        lat = 1;
        dc_ready = 1'b0;
        push(OP_SPILL, 32'h0000_0400, 7'd3);
        ins_req  = 1'b1;
        ins_we   = 1'b0;
        ins_addr = 32'h0000_0900;
        repeat (2) @(negedge clk);
        #1;
        check("R3 port carries queue head", dc_addr, 32'h0000_0400);
        check("R3 no grant while queue busy", ins_grant, 0);
        check("R6 spill presented as write", dc_we, 1);
        check("R6 register read enabled", rf_rd_en, 1);
        check("R6 register read index", rf_rd_preg, 3);
        @(negedge clk);
        dc_ready = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            #1;
            if (ins_grant) break;
        end
        @(negedge clk);
        ins_req = 1'b0;
        repeat (4) @(negedge clk);
        check("R3 spill first on port", lg_addr[b], 32'h0000_0400);
        check("R3 instruction after queue drains", lg_addr[b+1], 32'h0000_0900);
        check("R10 one instruction ack only", n_insack - ia, 1);
    endtask

    // R2 R4 R8: fill to full, drop an extra, drain in order
    task automatic t_full();
        int b = lg_n;
        int f = fd_n;
        int bad = 0;
        lat = 1;
        dc_ready = 1'b0;
        for (int i = 0; i < 7; i++) push(OP_FILL, 32'h1000 + 32'(i * 16), 7'(20 + i));
        #1;
        check("R2 not stalled at DEPTH-1", enq_stall, 0);
        @(negedge clk);
        push(OP_FILL, 32'h1070, 7'd27);
        #1;
        check("R2 stalled at DEPTH", enq_stall, 1);
        @(negedge clk);
        push(OP_FILL, 32'h000D_EAD0, 7'd99);
        #1;
        check("R2 still stalled", enq_stall, 1);
        @(negedge clk);
        dc_ready = 1'b1;
        wait_fills(f + 8);
        repeat (6) @(negedge clk);
        check("R2 dropped request never issued", lg_n - b, 8);
        for (int i = 0; i < 8; i++)
            if (lg_addr[b+i] != 32'h1000 + 32'(i * 16)) bad++;
        check("R4 drain order of full queue", bad, 0);
        check("R8 last fill register", fd_preg[f+7], 27);
        check("R8 fill count", fd_n - f, 8);
        #1;
        check("R2 stall released", enq_stall, 0);
    endtask

    // R7 R9: long latency keeps the port single-outstanding
    task automatic t_outstanding();
        int b = lg_n;
        int v0 = viol;
        lat = 5;
        push(OP_SPILL, 32'h0000_0040, 7'd1);
        push(OP_SPILL, 32'h0000_0044, 7'd2);
        wait_log(b + 2);
        repeat (10) @(negedge clk);
        check("R9 no request while outstanding", viol - v0, 0);
        check("R7 retire spacing at latency 5", lg_cyc[b+1], lg_cyc[b] + 6);
        check("R5 second spill address", lg_addr[b+1], 32'h0000_0044);
    endtask

    initial begin
        rst_n     = 1'b0;
        enq_valid = 1'b0;
        enq_op    = 1'b0;
        enq_addr  = '0;
        enq_preg  = '0;
        ins_req   = 1'b0;
        ins_we    = 1'b0;
        ins_addr  = '0;
        ins_wdata = '0;
        dc_ready  = 1'b1;
        dc_ack    = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        t_order();
        t_priority();
        @(negedge clk);
        t_full();
        @(negedge clk);
        t_outstanding();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule